// File: doc/BRIEF.md
# Capture Record Byte Serializer

This block sits between a capture buffer and a UART transmitter. After a start pulse it asks the buffer for one record at a time. A record holds a data word with one bit per channel, an 8-bit timestamp count, a flag that marks it as taken before or after the trigger, and a flag that marks it as the final record of the capture. Each record goes out as a short byte stream: first a header byte, then the data bytes, then the timestamp.

Both sides use a four-phase request/acknowledge handshake. A byte is held on the transmit side until the transmitter has acknowledged it and then withdrawn that acknowledge. A new record is requested only after every byte of the current record has completed its handshake. After the final record has gone out, the block raises a one-cycle completion pulse and returns to idle.

Top module: `rec_byte_serializer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `fetch_req`, `tx_req` and `done` are low.
- R2: A `start` pulse while idle raises `fetch_req`. A `start` while a capture is being sent is ignored: no extra record is fetched after that capture finishes.
- R3: The first byte of each record is a header: 0xA1 when `fetch_post` was 0 (pre-trigger), 0xA3 when it was 1 (post-trigger).
- R4: After the header come CHANNELS/8 data bytes, least significant first: data byte k carries `fetch_data[8k+7:8k]`.
- R5: The last byte of each record is the timestamp `fetch_stamp`, which ranges from 1 to 255.
- R6: `tx_req` stays high with `tx_byte` stable until `tx_ack` is seen. `tx_req` then falls and does not rise again while `tx_ack` is high.
- R7: `fetch_req` stays high until `fetch_ack` is seen, and the record fields are taken in that cycle. `fetch_req` does not rise while `fetch_ack` is high, nor before all bytes of the previous record have completed.
- R8: `done` pulses for exactly one cycle, one cycle after the final byte of a record marked with `fetch_last` completes its handshake. No pulse follows records without `fetch_last`. The block is idle afterwards.
- R9: The header byte may be offered on `tx_req` while the buffer still holds `fetch_ack` high from the fetch that delivered that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin sending a capture |
| fetch_req | output | 1 | Record request to the buffer |
| fetch_ack | input | 1 | Buffer acknowledge; record fields valid while high |
| fetch_data | input | CHANNELS | Channel data of the record |
| fetch_stamp | input | 8 | Timestamp count of the record |
| fetch_post | input | 1 | 1 = record taken after the trigger |
| fetch_last | input | 1 | 1 = final record of the capture |
| tx_req | output | 1 | Byte request to the transmitter |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_ack | input | 1 | Transmitter acknowledge |
| done | output | 1 | One-cycle pulse after the final record |

## Verification
The release of the fetch handshake and the first byte of the new record can occur in the same cycles. The serializer drops `fetch_req` and then offers the header without waiting for the buffer to lower `fetch_ack`. The bench's buffer model holds `fetch_ack` high for several cycles on some records to provoke this. A monitor records that `tx_req` and `fetch_ack` were high together, and the byte stream of that record is still compared byte by byte with values built from the stimulus table. A second overlap comes from a `start` issued in the middle of a capture. It is judged by showing that, after `done`, no further fetch is made and the buffer's record pointer has not moved.

// File: rtl/recser_pkg.sv
package recser_pkg;

    localparam logic [7:0] HDR_PRE  = 8'hA1;
    localparam logic [7:0] HDR_POST = 8'hA3;
    localparam int         BYTE_W   = 8;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_SEND
    } seq_state_e;

    typedef enum logic [1:0] {
        TX_FREE,
        TX_WAIT_ACK,
        TX_WAIT_REL
    } tx_state_e;

    function automatic logic [7:0] header_code(input logic post);
        return post ? HDR_POST : HDR_PRE;
    endfunction

endpackage

// File: rtl/recser_fetch_port.sv
module recser_fetch_port (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic fetch_ack,
    output logic fetch_req,
    output logic got
);

    assign got = fetch_req && fetch_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_req <= 1'b0;
        end else if (fetch_req && fetch_ack) begin
            fetch_req <= 1'b0;
        end else if (want && !fetch_req && !fetch_ack) begin
            fetch_req <= 1'b1;
        end
    end

    // R7: request held until acknowledged
    p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> fetch_req);

    // R7: no new request while the previous acknowledge is still high
    p_no_req_over_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req && fetch_ack) |=> !fetch_req);

endmodule

// File: rtl/recser_tx_port.sv
module recser_tx_port
    import recser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       send,
    input  logic [7:0] byte_in,
    input  logic       tx_ack,
    output logic       tx_req,
    output logic [7:0] tx_byte,
    output logic       free,
    output logic       byte_done
);

    tx_state_e st;

    assign free      = (st == TX_FREE);
    assign byte_done = (st == TX_WAIT_REL) && !tx_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TX_FREE;
            tx_req  <= 1'b0;
            tx_byte <= '0;
        end else begin
            case (st)
                TX_FREE: begin
                    if (send) begin
                        tx_byte <= byte_in;
                        tx_req  <= 1'b1;
                        st      <= TX_WAIT_ACK;
                    end
                end
                TX_WAIT_ACK: begin
                    if (tx_ack) begin
                        tx_req <= 1'b0;
                        st     <= TX_WAIT_REL;
                    end
                end
                TX_WAIT_REL: begin
                    if (!tx_ack) begin
                        st <= TX_FREE;
                    end
                end
                default: st <= TX_FREE;
            endcase
        end
    end

    // R6: byte held stable until acknowledged
    p_byte_held_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_ack) |=> (tx_req && $stable(tx_byte)));

    // R6: no new byte while the acknowledge is still high
    p_wait_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!tx_req && tx_ack) |=> !tx_req);

endmodule

// File: rtl/recser_byte_pick.sv
module recser_byte_pick #(
    parameter int REC_BYTES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [REC_BYTES*8-1:0] rec_flat,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             byte_out
);

    logic [7:0] lane [REC_BYTES];

    for (genvar k = 0; k < REC_BYTES; k++) begin : g_lane
        assign lane[k] = rec_flat[k*8 +: 8];
    end

    always_comb begin
        byte_out = '0;
        for (int k = 0; k < REC_BYTES; k++) begin
            if (idx == IDX_W'(k)) begin
                byte_out = lane[k];
            end
        end
    end

endmodule

// File: rtl/rec_byte_serializer.sv
module rec_byte_serializer
    import recser_pkg::*;
#(
    parameter int CHANNELS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                fetch_req,
    input  logic                fetch_ack,
    input  logic [CHANNELS-1:0] fetch_data,
    input  logic [7:0]          fetch_stamp,
    input  logic                fetch_post,
    input  logic                fetch_last,
    output logic                tx_req,
    output logic [7:0]          tx_byte,
    input  logic                tx_ack,
    output logic                done
);

    localparam int DATA_BYTES = CHANNELS / BYTE_W;
    localparam int REC_BYTES  = DATA_BYTES + 2;
    localparam int IDX_W      = $clog2(REC_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

    seq_state_e               st;
    logic [IDX_W-1:0]         idx;
    logic [REC_BYTES*8-1:0]   rec_q;
    logic                     last_q;
    logic                     got;
    logic                     tx_free;
    logic                     byte_done;
    logic                     send;
    logic [7:0]               cur_byte;

    recser_fetch_port u_fetch (
        .clk       (clk),
        .rst       (rst),
        .want      (st == SQ_FETCH),
        .fetch_ack (fetch_ack),
        .fetch_req (fetch_req),
        .got       (got)
    );

    recser_byte_pick #(
        .REC_BYTES (REC_BYTES),
        .IDX_W     (IDX_W)
    ) u_pick (
        .rec_flat (rec_q),
        .idx      (idx),
        .byte_out (cur_byte)
    );

    assign send = (st == SQ_SEND) && tx_free;

    recser_tx_port u_tx (
        .clk       (clk),
        .rst       (rst),
        .send      (send),
        .byte_in   (cur_byte),
        .tx_ack    (tx_ack),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .free      (tx_free),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            idx    <= '0;
            rec_q  <= '0;
            last_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (got) begin
                        rec_q  <= {fetch_stamp, fetch_data, header_code(fetch_post)};
                        last_q <= fetch_last;
                        idx    <= '0;
                        st     <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (byte_done) begin
                        if (idx == LAST_IDX) begin
                            if (last_q) begin
                                done <= 1'b1;
                                st   <= SQ_IDLE;
                            end else begin
                                st <= SQ_FETCH;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R3: the first byte offered for a record is a valid header
    p_header_first_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_req && idx == '0) |-> (tx_byte == HDR_PRE || tx_byte == HDR_POST));

    // R7: a fetch starts only with no byte outstanding
    p_fetch_after_record_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req) |-> !tx_req);

    // R8: completion is a single-cycle pulse with both sides quiet
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!fetch_req && !tx_req));

    // R2: start while sending does not leave the sending state
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_SEND && start && !byte_done) |=> (st == SQ_SEND));

endmodule

// File: tb/test_rec_byte_serializer.sv
module test_rec_byte_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int CH   = 16;
    localparam int DB   = CH / 8;
    localparam int RB   = DB + 2;
    localparam int NREC = 6;
    localparam int NSES = 3;

    // [25] post flag, [24] final flag, [23:16] stamp, [15:0] data
    localparam logic [25:0] REC_TAB [NREC] = '{
        {1'b0, 1'b0, 8'd1,   16'h1234},
        {1'b0, 1'b0, 8'd255, 16'hBEEF},
        {1'b1, 1'b1, 8'd7,   16'h00FF},
        {1'b1, 1'b0, 8'd128, 16'hA5C3},
        {1'b0, 1'b1, 8'd42,  16'h8001},
        {1'b1, 1'b1, 8'd1,   16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          fetch_req;
    logic          fetch_ack;
    logic [CH-1:0] fetch_data;
    logic [7:0]    fetch_stamp;
    logic          fetch_post;
    logic          fetch_last;
    logic          tx_req;
    logic [7:0]    tx_byte;
    logic          tx_ack;
    logic          done;

    int   checks = 0;
    int   fails  = 0;
    int   ptr    = 0;
    int   nbytes = 0;
    bit   overlap_seen = 1'b0;
    logic prev_freq = 1'b0;
    logic [7:0] got [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    rec_byte_serializer #(.CHANNELS(CH)) i_rec_byte_serializer (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .fetch_req   (fetch_req),
        .fetch_ack   (fetch_ack),
        .fetch_data  (fetch_data),
        .fetch_stamp (fetch_stamp),
        .fetch_post  (fetch_post),
        .fetch_last  (fetch_last),
        .tx_req      (tx_req),
        .tx_byte     (tx_byte),
        .tx_ack      (tx_ack),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // buffer model
    initial begin
        fetch_ack = 1'b0; fetch_data = '0; fetch_stamp = '0;
        fetch_post = 1'b0; fetch_last = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && fetch_req && !fetch_ack) begin
                repeat (ptr % 3) @(negedge clk);
                if (ptr >= NREC) begin
                    check(1'b0, "R7 fetch beyond table", ptr, NREC - 1);
                end else begin
                    {fetch_post, fetch_last, fetch_stamp, fetch_data} = REC_TAB[ptr];
                    fetch_ack = 1'b1;
                    ptr++;
                end
            end else if (!fetch_req && fetch_ack) begin
                repeat ((ptr % 2) * 3) @(negedge clk);
                fetch_ack = 1'b0;
            end
        end
    end

    // transmitter model
    initial begin
        tx_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && tx_req && !tx_ack) begin
                logic [7:0] held;
                held = tx_byte;
                repeat (nbytes % 3) @(negedge clk);
                check(tx_byte == held, "R6 byte stable", tx_byte, held);
                got[nbytes % 64] = tx_byte;
                nbytes++;
                tx_ack = 1'b1;
            end else if (!tx_req && tx_ack) begin
                repeat ((nbytes % 2) * 2) @(negedge clk);
                tx_ack = 1'b0;
            end
        end
    end

    // handshake monitor, sampled just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (fetch_req && !prev_freq)
                    check(nbytes % RB == 0, "R7 fetch after full record", nbytes % RB, 0);
                if (fetch_ack)
                    check(!fetch_req, "R7 request drops on ack", fetch_req, 0);
                if (tx_ack)
                    check(!tx_req, "R6 request low while ack high", tx_req, 0);
                if (fetch_ack && tx_req)
                    overlap_seen = 1'b1;
            end
            prev_freq = fetch_req;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int first;
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(!fetch_req && !tx_req && !done, "R1 reset outputs",
              {fetch_req, tx_req, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!fetch_req && !tx_req && !done, "R1 first cycle after reset",
              {fetch_req, tx_req, done}, 0);
        repeat (5) @(negedge clk);
        check(!fetch_req, "R2 no fetch without start", fetch_req, 0);

        first = 0;
        for (int s = 0; s < NSES; s++) begin
            int last_rec;
            int t;
            last_rec = first;
            while (!REC_TAB[last_rec][24]) last_rec++;

            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (s == 1) begin
                while (nbytes < first * RB + 3) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end

            t = 0;
            while (!done && t < 5000) begin
                @(negedge clk);
                t++;
            end
            check(done, "R8 done raised", done, 1);
            check(nbytes == (last_rec + 1) * RB, "R8 done after final byte",
                  nbytes, (last_rec + 1) * RB);
            @(negedge clk);
            check(!done, "R8 done one cycle", done, 0);

            for (int r = first; r <= last_rec; r++) begin
                logic [7:0] hdr;
                hdr = REC_TAB[r][25] ? 8'hA3 : 8'hA1;
                check(got[r*RB] == hdr, "R3 header byte", got[r*RB], hdr);
                for (int k = 0; k < DB; k++)
                    check(got[r*RB + 1 + k] == REC_TAB[r][k*8 +: 8], "R4 data byte order",
                          got[r*RB + 1 + k], REC_TAB[r][k*8 +: 8]);
                check(got[r*RB + RB - 1] == REC_TAB[r][23:16], "R5 timestamp last",
                      got[r*RB + RB - 1], REC_TAB[r][23:16]);
            end

            repeat (20) @(negedge clk);
            check(!fetch_req && ptr == last_rec + 1, "R2 R8 idle after capture",
                  ptr, last_rec + 1);
            first = last_rec + 1;
        end

        check(overlap_seen, "R9 header offered while fetch ack high", overlap_seen, 1);
        summary();
    end

endmodule